// File: doc/BRIEF.md
# Fractional Ratio Parameter Encoder

This block turns a fractional divide ratio, written as an integer part `a` plus a fraction `b/c`, into the three packed parameters that a fractional synthesizer stage expects. It then streams them out as an eight-byte register image, one byte per cycle, ready for a configuration bus master to write. The first parameter is `128*a + floor(128*b/c) - 512`. The second is the remainder of `128*b` divided by `c`. The third is `c` itself. A restoring divider resolves the floor term at one quotient bit per clock.

Two modes are supported. Feedback mode encodes a loop multiplier and has a narrow legal range for `a`. Output mode encodes a post-divider and has a wider ratio window. Output mode also carries a 3-bit output-divide code and a divide-by-4 flag inside the image. An illegal request still finishes after the same latency. It raises an error flag with the done pulse and sends no bytes.

Top module: `ratio_param_encoder`

## Requirements
- R1: When b is not 0, P1 (18 bits) equals (128*a + floor(128*b/c) - 512) modulo 2^18.
- R2: When b is not 0, P2 (20 bits) equals the remainder of 128*b divided by c.
- R3: P3 (20 bits) equals c.
- R4: When b is 0, no quotient is used: P1 = 128*a - 512 and P2 = 0.
- R5: c = 0 is illegal in either mode and sets err_o with done_o.
- R6: mode_i = 0 selects feedback mode, where a must lie in 15..90 and otherwise err_o is set.
- R7: mode_i = 1 selects output mode. Here a must be at least 4, and either b = 0 with a at most 6, or a + floor(b/c) must lie in 6..1800. Otherwise err_o is set.
- R8: The image is sent with byte_idx_o counting 0 to 7 on consecutive cycles. The bytes are, in index order: P3[15:8], P3[7:0], byte 2 with P1[17:16] in bits 1:0, P1[15:8], P1[7:0], byte 5 with P3[19:16] in bits 7:4 and P2[19:16] in bits 3:0, P2[15:8], P2[7:0].
- R9: Byte 2 bit 7 is 0. In output mode, bits 6:4 carry odiv_i and bits 3:2 are both 1 when div4_i is 1, else 0. In feedback mode, bits 7:2 are all 0.
- R10: done_o is a one-cycle pulse on the 36th rising edge after the edge that accepts start_i. Index 0 of the image appears after edge 28 and index 7 after edge 35. Everything is low after reset.
- R11: err_o is only high together with done_o. An illegal request sends no bytes (byte_valid_o stays low).
- R12: Inputs are captured at the accepting edge. A start_i, or any input change, while a request is in progress has no effect on that result and does not start a second request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request pulse, accepted when idle |
| mode_i | input | 1 | 0 = feedback mode, 1 = output mode |
| a_i | input | AW | Integer part of the ratio |
| b_i | input | BW | Fraction numerator |
| c_i | input | BW | Fraction denominator |
| odiv_i | input | 3 | Output-divide code (output mode) |
| div4_i | input | 1 | Divide-by-4 select (output mode) |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Illegal request, valid with done_o |
| byte_valid_o | output | 1 | Image byte present |
| byte_idx_o | output | 3 | Index of the byte present |
| byte_o | output | 8 | Image byte |

## Verification
The hardest cases to reach are the range-check corners that depend on the quotient rather than on `a` alone. One is an output-mode request with b ≥ c, where floor(b/c) lifts a small `a` into the legal window. Another is a feedback request with the largest numerator and c = 1, which fills all 27 quotient bits and wraps P1. Both are driven as directed requests next to the two reference ratio pairs. Input latching is exercised by changing every input after the accepting edge and by pulsing start again mid-division, then confirming the first result and the absence of a second done.

// File: rtl/rpe_pkg.sv
package rpe_pkg;
    localparam int P1W = 18;
    localparam int P2W = 20;
    localparam int P3W = 20;
    localparam int IMG_BYTES = 8;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_DIV  = 3'd1,
        ST_FIN  = 3'd2,
        ST_EMIT = 3'd3,
        ST_DONE = 3'd4
    } rpe_state_e;

    typedef enum logic {
        MODE_FEEDBACK = 1'b0,
        MODE_OUTPUT   = 1'b1
    } rpe_mode_e;
endpackage

// File: rtl/rpe_restoring_div.sv
module rpe_restoring_div #(
    parameter int NW = 27,
    parameter int DW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          step_i,
    input  logic [NW-1:0] dividend_i,
    input  logic [DW-1:0] divisor_i,
    output logic [NW-1:0] quot_o,
    output logic [DW-1:0] rem_o
);
    typedef struct packed {
        logic [NW-1:0] num;
        logic [DW-1:0] rem;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [DW:0] trial;
    logic [DW:0] diff;
    logic        fits;

    always_comb begin
        st_d  = st_q;
        trial = {st_q.rem, st_q.num[NW-1]};
        fits  = (trial >= {1'b0, divisor_i});
        diff  = trial - {1'b0, divisor_i};
        if (load_i) begin
            st_d.num = dividend_i;
            st_d.rem = '0;
        end else if (step_i) begin
            st_d.num = {st_q.num[NW-2:0], fits};
            st_d.rem = fits ? diff[DW-1:0] : trial[DW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign quot_o = st_q.num;
    assign rem_o  = st_q.rem;
endmodule

// File: rtl/rpe_range_check.sv
module rpe_range_check #(
    parameter int AW          = 11,
    parameter int QIW         = 20,
    parameter int FB_MIN      = 15,
    parameter int FB_MAX      = 90,
    parameter int OUT_A_MIN   = 4,
    parameter int OUT_INT_MAX = 6,
    parameter int OUT_MIN     = 6,
    parameter int OUT_MAX     = 1800
) (
    input  logic           mode_out_i,
    input  logic [AW-1:0]  a_i,
    input  logic [QIW-1:0] q_int_i,
    input  logic           b_zero_i,
    input  logic           c_zero_i,
    output logic           illegal_o
);
    localparam int SW = ((AW > QIW) ? AW : QIW) + 1;

    logic [SW-1:0] total;
    logic          fb_bad;
    logic          out_ok;

    always_comb begin
        total  = SW'(a_i) + SW'(q_int_i);
        fb_bad = (a_i < AW'(FB_MIN)) || (a_i > AW'(FB_MAX));
        out_ok = (a_i >= AW'(OUT_A_MIN)) &&
                 ((b_zero_i && (a_i <= AW'(OUT_INT_MAX))) ||
                  ((total >= SW'(OUT_MIN)) && (total <= SW'(OUT_MAX))));
        illegal_o = c_zero_i || (mode_out_i ? !out_ok : fb_bad);
    end
endmodule

// File: rtl/rpe_byte_pack.sv
module rpe_byte_pack
    import rpe_pkg::*;
(
    input  logic [P1W-1:0] p1_i,
    input  logic [P2W-1:0] p2_i,
    input  logic [P3W-1:0] p3_i,
    input  logic           mode_out_i,
    input  logic [2:0]     odiv_i,
    input  logic           div4_i,
    input  logic [2:0]     idx_i,
    output logic [7:0]     byte_o
);
    logic [5:0] mode_bits;

    always_comb begin
        mode_bits = mode_out_i ? {1'b0, odiv_i, div4_i, div4_i} : 6'd0;
        unique case (idx_i)
            3'd0:    byte_o = p3_i[15:8];
            3'd1:    byte_o = p3_i[7:0];
            3'd2:    byte_o = {mode_bits, p1_i[17:16]};
            3'd3:    byte_o = p1_i[15:8];
            3'd4:    byte_o = p1_i[7:0];
            3'd5:    byte_o = {p3_i[19:16], p2_i[19:16]};
            3'd6:    byte_o = p2_i[15:8];
            default: byte_o = p2_i[7:0];
        endcase
    end
endmodule

// File: rtl/ratio_param_encoder.sv
module ratio_param_encoder
    import rpe_pkg::*;
#(
    parameter int AW     = 11,
    parameter int BW     = 20,
    parameter int FRAC   = 7,
    parameter int OFFSET = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          mode_i,
    input  logic [AW-1:0] a_i,
    input  logic [BW-1:0] b_i,
    input  logic [BW-1:0] c_i,
    input  logic [2:0]    odiv_i,
    input  logic          div4_i,
    output logic          done_o,
    output logic          err_o,
    output logic          byte_valid_o,
    output logic [2:0]    byte_idx_o,
    output logic [7:0]    byte_o
);
    localparam int QW   = BW + FRAC;
    localparam int CW   = $clog2(QW);
    localparam int SUMW = ((AW + FRAC > QW) ? AW + FRAC : QW) + 1;

    typedef struct packed {
        rpe_state_e     st;
        logic [CW-1:0]  cnt;
        logic [AW-1:0]  a;
        logic [BW-1:0]  b;
        logic [BW-1:0]  c;
        rpe_mode_e      mode;
        logic [2:0]     odiv;
        logic           div4;
        logic [P1W-1:0] p1;
        logic [P2W-1:0] p2;
        logic           err;
        logic [2:0]     idx;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic            div_load, div_step;
    logic [QW-1:0]   quot, q_eff;
    logic [BW-1:0]   rem, r_eff;
    logic            b_zero;
    logic [SUMW-1:0] p1_sum;
    logic            illegal;
    logic [7:0]      packed_byte;

    rpe_restoring_div #(.NW(QW), .DW(BW)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (div_load),
        .step_i     (div_step),
        .dividend_i ({b_i, {FRAC{1'b0}}}),
        .divisor_i  (ctl_q.c),
        .quot_o     (quot),
        .rem_o      (rem)
    );

    rpe_range_check #(.AW(AW), .QIW(QW - FRAC)) u_range (
        .mode_out_i (ctl_q.mode == MODE_OUTPUT),
        .a_i        (ctl_q.a),
        .q_int_i    (q_eff[QW-1:FRAC]),
        .b_zero_i   (b_zero),
        .c_zero_i   (ctl_q.c == '0),
        .illegal_o  (illegal)
    );

    rpe_byte_pack u_pack (
        .p1_i       (ctl_q.p1),
        .p2_i       (ctl_q.p2),
        .p3_i       (P3W'(ctl_q.c)),
        .mode_out_i (ctl_q.mode == MODE_OUTPUT),
        .odiv_i     (ctl_q.odiv),
        .div4_i     (ctl_q.div4),
        .idx_i      (ctl_q.idx),
        .byte_o     (packed_byte)
    );

    always_comb begin
        b_zero = (ctl_q.b == '0);
        q_eff  = b_zero ? '0 : quot;
        r_eff  = b_zero ? '0 : rem;
        p1_sum = SUMW'({ctl_q.a, {FRAC{1'b0}}}) + SUMW'(q_eff) - SUMW'(OFFSET);
    end

    always_comb begin
        ctl_d    = ctl_q;
        div_load = 1'b0;
        div_step = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.st   = ST_DIV;
                    ctl_d.cnt  = CW'(QW - 1);
                    ctl_d.a    = a_i;
                    ctl_d.b    = b_i;
                    ctl_d.c    = c_i;
                    ctl_d.mode = rpe_mode_e'(mode_i);
                    ctl_d.odiv = odiv_i;
                    ctl_d.div4 = div4_i;
                    ctl_d.err  = 1'b0;
                    div_load   = 1'b1;
                end
            end
            ST_DIV: begin
                div_step = 1'b1;
                if (ctl_q.cnt == '0) ctl_d.st  = ST_FIN;
                else                 ctl_d.cnt = ctl_q.cnt - 1'b1;
            end
            ST_FIN: begin
                ctl_d.p1  = p1_sum[P1W-1:0];
                ctl_d.p2  = P2W'(r_eff);
                ctl_d.err = illegal;
                ctl_d.idx = 3'd0;
                ctl_d.st  = ST_EMIT;
            end
            ST_EMIT: begin
                if (ctl_q.idx == 3'd7) ctl_d.st  = ST_DONE;
                else                   ctl_d.idx = ctl_q.idx + 3'd1;
            end
            ST_DONE: ctl_d.st = ST_IDLE;
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign done_o       = (ctl_q.st == ST_DONE);
    assign err_o        = done_o && ctl_q.err;
    assign byte_valid_o = (ctl_q.st == ST_EMIT) && !ctl_q.err;
    assign byte_idx_o   = ctl_q.idx;
    assign byte_o       = byte_valid_o ? packed_byte : 8'd0;
endmodule

// File: rtl/rpe_checker.sv
module rpe_checker #(
    parameter int QW = 27
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       busy_i,
    input logic       mode_out_i,
    input logic       done_o,
    input logic       err_o,
    input logic       byte_valid_o,
    input logic [2:0] byte_idx_o,
    input logic [7:0] byte_o
);
    localparam int LATW = $clog2(QW + 16) + 1;

    logic            run_q;
    logic [LATW-1:0] lat_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            lat_q <= '0;
        end else if (start_i && !busy_i) begin
            run_q <= 1'b1;
            lat_q <= '0;
        end else if (done_o) begin
            run_q <= 1'b0;
        end else if (run_q) begin
            lat_q <= lat_q + 1'b1;
        end
    end

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (run_q && lat_q == LATW'(QW + 9)));

    assert_idx_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid_o && byte_idx_o != 3'd7) |=>
        (byte_valid_o && byte_idx_o == 3'($past(byte_idx_o) + 3'd1)));

    assert_first_idx_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(byte_valid_o) |-> byte_idx_o == 3'd0);

    assert_err_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o);

    assert_err_no_bytes_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o) |-> !$past(byte_valid_o));

    assert_fb_fields_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid_o && byte_idx_o == 3'd2 && !mode_out_i) |-> byte_o[7:2] == 6'd0);

    assert_no_done_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_i);
endmodule

bind ratio_param_encoder rpe_checker #(.QW(BW + FRAC)) u_rpe_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .busy_i       (ctl_q.st != rpe_pkg::ST_IDLE),
    .mode_out_i   (ctl_q.mode == rpe_pkg::MODE_OUTPUT),
    .done_o       (done_o),
    .err_o        (err_o),
    .byte_valid_o (byte_valid_o),
    .byte_idx_o   (byte_idx_o),
    .byte_o       (byte_o)
);

// File: tb/tb_ratio_param_encoder.sv
module tb_ratio_param_encoder;
    localparam int AW  = 11;
    localparam int BW  = 20;
    localparam int LAT = 36;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          mode_i = 1'b0;
    logic [AW-1:0] a_i = '0;
    logic [BW-1:0] b_i = '0;
    logic [BW-1:0] c_i = '0;
    logic [2:0]    odiv_i = '0;
    logic          div4_i = 1'b0;
    logic          done_o, err_o, byte_valid_o;
    logic [2:0]    byte_idx_o;
    logic [7:0]    byte_o;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    ratio_param_encoder #(.AW(AW), .BW(BW)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .a_i(a_i), .b_i(b_i), .c_i(c_i), .odiv_i(odiv_i), .div4_i(div4_i),
        .done_o(done_o), .err_o(err_o), .byte_valid_o(byte_valid_o),
        .byte_idx_o(byte_idx_o), .byte_o(byte_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic run(input string ereq, input bit md, input longint a, input longint b,
                       input longint c, input int odiv, input bit d4, input bit poke);
        logic [7:0] img [8];
        int     nb = 0;
        int     done_k = -1;
        bit     got_err = 1'b0;
        longint q, r, p1, p2, p3, rint;
        bit     exp_err;
        longint got1, got2, got3, hi_exp;

        q    = (b == 0 || c == 0) ? 0 : (128 * b) / c;
        r    = (b == 0 || c == 0) ? 0 : (128 * b) % c;
        rint = (c == 0) ? 0 : a + b / c;
        p1   = (128 * a + q - 512) & 64'h3FFFF;
        p2   = r;
        p3   = c;
        if (c == 0) exp_err = 1'b1;
        else if (!md) exp_err = (a < 15) || (a > 90);
        else exp_err = (a < 4) || !((b == 0 && a <= 6) || (rint >= 6 && rint <= 1800));
        for (int i = 0; i < 8; i++) img[i] = 8'h00;

        @(negedge clk);
        start_i = 1'b1; mode_i = md; a_i = AW'(a); b_i = BW'(b); c_i = BW'(c);
        odiv_i = 3'(odiv); div4_i = d4;
        for (int k = 1; k <= LAT + 20; k++) begin
            @(negedge clk);
            if (k == 1) begin
                start_i = 1'b0; mode_i = ~md; a_i = ~a_i; b_i = ~b_i; c_i = ~c_i;
                odiv_i = ~odiv_i; div4_i = ~d4;
            end
            if (poke && k == 5) start_i = 1'b1;
            if (poke && k == 6) start_i = 1'b0;
            if (byte_valid_o) begin
                chk(byte_idx_o == 3'(nb), "R8 byte index order", longint'(byte_idx_o), nb);
                if (nb < 8) img[nb] = byte_o;
                nb++;
            end
            if (done_o) begin
                done_k  = k;
                got_err = err_o;
                break;
            end
        end

        chk(done_k == LAT + 1, "R10 done latency", done_k - 1, LAT);
        chk(got_err == exp_err, ereq, longint'(got_err), longint'(exp_err));
        if (exp_err) begin
            chk(nb == 0, "R11 no bytes on error", nb, 0);
        end else begin
            chk(nb == 8, "R10 byte count", nb, 8);
            got1 = {img[2][1:0], img[3], img[4]};
            got2 = {img[5][3:0], img[6], img[7]};
            got3 = {img[5][7:4], img[0], img[1]};
            chk(got1 == p1, (b == 0) ? "R4 P1 without quotient" : "R1 P1 value", got1, p1);
            chk(got2 == p2, (b == 0) ? "R4 P2 zero" : "R2 P2 remainder", got2, p2);
            chk(got3 == p3, "R3 P3 value and R8 nibble split", got3, p3);
            hi_exp = md ? {1'b0, 3'(odiv), d4, d4} : 0;
            chk(img[2][7:2] == 6'(hi_exp), "R9 mode bits in byte 2", img[2][7:2], hi_exp);
        end

        if (poke) begin
            bit extra = 1'b0;
            for (int k = 0; k < LAT + 10; k++) begin
                @(negedge clk);
                if (done_o || byte_valid_o) extra = 1'b1;
            end
            chk(!extra, "R12 start while busy ignored", longint'(extra), 0);
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(!done_o && !err_o && !byte_valid_o, "R10 reset state",
            {done_o, err_o, byte_valid_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!done_o && !byte_valid_o, "R10 idle after reset", {done_o, byte_valid_o}, 0);
    endtask

    task automatic t_ref_pairs();
        run("R7 pair one legal", 1'b1, 41, 60725, 67117, 0, 1'b0, 1'b0);
        run("R7 pair two legal", 1'b1, 36, 36834, 64081, 5, 1'b1, 1'b0);
        run("R6 pair two in feedback", 1'b0, 36, 36834, 64081, 7, 1'b1, 1'b0);
    endtask

    task automatic t_bzero();
        run("R7 integer ratio 5", 1'b1, 5, 0, 1, 3, 1'b0, 1'b0);
        run("R6 feedback integer 36", 1'b0, 36, 0, 1, 7, 1'b1, 1'b0);
        run("R7 integer ratio 4", 1'b1, 4, 0, 9, 2, 1'b1, 1'b0);
    endtask

    task automatic t_czero();
        run("R5 c zero feedback", 1'b0, 36, 100, 0, 0, 1'b0, 1'b0);
        run("R5 c zero output", 1'b1, 40, 0, 0, 0, 1'b0, 1'b0);
    endtask

    task automatic t_fb_range();
        run("R6 a=14 rejected", 1'b0, 14, 1, 3, 0, 1'b0, 1'b0);
        run("R6 a=15 accepted", 1'b0, 15, 1, 3, 0, 1'b0, 1'b0);
        run("R6 a=90 accepted", 1'b0, 90, 2, 7, 0, 1'b0, 1'b0);
        run("R6 a=91 rejected", 1'b0, 91, 0, 1, 0, 1'b0, 1'b0);
        run("R1 full quotient wrap", 1'b0, 90, 1048575, 1, 0, 1'b0, 1'b0);
    endtask

    task automatic t_out_range();
        run("R7 a=3 rejected", 1'b1, 3, 0, 1, 0, 1'b0, 1'b0);
        run("R7 fractional 5.5 rejected", 1'b1, 5, 1, 2, 0, 1'b0, 1'b0);
        run("R7 b over c lifts to 6", 1'b1, 4, 100, 50, 1, 1'b0, 1'b0);
        run("R7 ratio 1800 accepted", 1'b1, 1800, 1, 3, 6, 1'b1, 1'b0);
        run("R7 ratio 1801 rejected", 1'b1, 1801, 0, 1, 0, 1'b0, 1'b0);
        run("R7 integer 7 accepted", 1'b1, 7, 0, 5, 0, 1'b0, 1'b0);
    endtask

    task automatic t_busy();
        run("R12 latched pair one", 1'b1, 41, 60725, 67117, 4, 1'b1, 1'b1);
    endtask

    initial begin
        t_reset();
        t_ref_pairs();
        t_bzero();
        t_czero();
        t_fb_range();
        t_out_range();
        t_busy();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule